// File: doc/BRIEF.md
# Word-Sliced Dual-Port Memory Core

This block holds `DEPTH` words of `DATA_W` bits and makes them reachable from two sides at once. A user port sees the storage as a flat array of full-width words. A host register port sees the same bits as 16-bit words. Each user word is cut into `ceil(DATA_W/16)` slices, and each slice lives in its own memory of `DEPTH` rows. Slice `i` of user row `a` is found on the register port at `BASE_ADDR + a + i*DEPTH`. The last slice is only as wide as the remainder of `DATA_W` over 16.

A build-time mode decides who may write. In bidirectional mode both ports write and both ports read. In capture mode only the user side writes and only the host side reads; the user read port then returns zero. In playback mode only the host writes and only the user side reads; host reads then return no valid data. Every location clears to zero under reset.

Top module: `wsm_core`

## Requirements
- R1: After reset every location reads as zero from both ports.
- R2: Bits `[16*i+15:16*i]` of user row `a` are the slice at host address `BASE_ADDR + a + i*DEPTH`, with slice 0 holding the least significant bits.
- R3: On the last slice, which is `DATA_W mod 16` bits wide when that remainder is non-zero, a host write keeps only the low bits, and a host read returns the unused upper bits as zero.
- R4: A host read strobe at an address inside the window gives `bus_rvalid` = 1 with the stored slice on `bus_rdata` one clock later. `bus_rvalid` is 0 in every cycle that does not follow such a read.
- R5: Host addresses below `BASE_ADDR` or at or above `BASE_ADDR + ceil(DATA_W/16)*DEPTH` are ignored: reads give no `bus_rvalid`, and writes change no location.
- R6: A user write commits when `user_we` is high for one clock with the address and data valid. `user_rdata` shows the word at `user_addr` one clock edge after the address is applied, and the bench samples it within two edges.
- R7: In bidirectional mode (`MODE` = `WSM_BIDIR`) a write through either port is read back at the matching location through the other port.
- R8: In capture mode (`MODE` = `WSM_USER_WR`) host writes are discarded, host reads work, and `user_rdata` is always zero.
- R9: In playback mode (`MODE` = `WSM_HOST_WR`) user writes are discarded, user reads work, and `bus_rvalid` is never raised.
- R10: If a user write and a host write hit the same slice in the same clock, the host data is stored in that slice and the user data is stored in the other slices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears all storage |
| user_addr | input | ROW_W | User row address |
| user_wdata | input | DATA_W | User write word |
| user_we | input | 1 | User write enable |
| user_rdata | output | DATA_W | Registered user read word |
| bus_addr | input | BUS_AW | Host register address |
| bus_wdata | input | 16 | Host write data |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_rdata | output | 16 | Host read data, zero-extended slice |
| bus_rvalid | output | 1 | Host read data valid |

## Verification
A user write and a host write can land in the same clock, and on the same row. The bench provokes this by raising `user_we` and `bus_wr` on the same edge, once aimed at slice 0 and once at the narrow last slice. It then reads the row back through both ports. It passes only if the host data owns the targeted slice while the user data fills the remaining slices. The same stimulus drives a capture-mode copy and a playback-mode copy, so the bench also confirms that each copy keeps only the write its mode allows.

// File: rtl/wsm_pkg.sv
package wsm_pkg;

    typedef enum logic [1:0] {
        WSM_BIDIR   = 2'd0,
        WSM_USER_WR = 2'd1,
        WSM_HOST_WR = 2'd2
    } wsm_mode_e;

    localparam int SLICE_W = 16;

    function automatic int slice_count(input int data_w);
        return (data_w + SLICE_W - 1) / SLICE_W;
    endfunction

    function automatic int slice_width(input int data_w, input int idx);
        int rem;
        rem = data_w - idx * SLICE_W;
        return (rem >= SLICE_W) ? SLICE_W : rem;
    endfunction

endpackage

// File: rtl/wsm_decode.sv
module wsm_decode #(
    parameter int BUS_AW    = 16,
    parameter int BASE_ADDR = 256,
    parameter int DEPTH     = 32,
    parameter int NSLICE    = 2,
    parameter int ROW_W     = 5
) (
    input  logic [BUS_AW-1:0] bus_addr,
    output logic              hit,
    output logic [NSLICE-1:0] sel,
    output logic [ROW_W-1:0]  row
);
    localparam int SPAN = NSLICE * DEPTH;

    logic [31:0] addr_ext;
    logic [31:0] offset;

    always_comb begin
        addr_ext = 32'(bus_addr);
        offset   = addr_ext - 32'(BASE_ADDR);
        hit      = (addr_ext >= 32'(BASE_ADDR)) && (offset < 32'(SPAN));
        sel      = '0;
        row      = '0;
        for (int i = 0; i < NSLICE; i++) begin
            if (hit && offset >= 32'(i * DEPTH) && offset < 32'((i + 1) * DEPTH)) begin
                sel[i] = 1'b1;
                row    = ROW_W'(offset - 32'(i * DEPTH));
            end
        end
    end

endmodule

// File: rtl/wsm_slice.sv
module wsm_slice #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 32,
    parameter int ROW_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             u_we,
    input  logic [ROW_W-1:0] u_addr,
    input  logic [WIDTH-1:0] u_wdata,
    output logic [WIDTH-1:0] u_rdata,
    input  logic             b_we,
    input  logic [ROW_W-1:0] b_addr,
    input  logic [WIDTH-1:0] b_wdata,
    output logic [WIDTH-1:0] b_rdata
);
    logic [DEPTH-1:0][WIDTH-1:0] mem_d;
    logic [DEPTH-1:0][WIDTH-1:0] mem_q;

    always_comb begin
        mem_d = mem_q;
        if (u_we) begin
            mem_d[u_addr] = u_wdata;
        end
        // host write is applied last so it owns a same-cycle collision
        if (b_we) begin
            mem_d[b_addr] = b_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign u_rdata = mem_q[u_addr];
    assign b_rdata = mem_q[b_addr];

endmodule

// File: rtl/wsm_core.sv
module wsm_core
    import wsm_pkg::*;
#(
    parameter int        DATA_W    = 23,
    parameter int        DEPTH     = 32,
    parameter int        BASE_ADDR = 256,
    parameter int        BUS_AW    = 16,
    parameter wsm_mode_e MODE      = WSM_BIDIR,
    localparam int       ROW_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ROW_W-1:0]  user_addr,
    input  logic [DATA_W-1:0] user_wdata,
    input  logic              user_we,
    output logic [DATA_W-1:0] user_rdata,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [15:0]       bus_rdata,
    output logic              bus_rvalid
);
    localparam int NSLICE = slice_count(DATA_W);

    typedef struct packed {
        logic [DATA_W-1:0] urd;
        logic [15:0]       brd;
        logic              bvld;
    } port_state_t;

    port_state_t st_d, st_q;

    logic              hit;
    logic [NSLICE-1:0] sel;
    logic [ROW_W-1:0]  brow;
    logic              u_we_ok;
    logic              b_we_ok;
    logic              b_rd_ok;
    logic [DATA_W-1:0] user_word;
    logic [NSLICE-1:0][15:0] bus_slice_rd;

    wsm_decode #(
        .BUS_AW   (BUS_AW),
        .BASE_ADDR(BASE_ADDR),
        .DEPTH    (DEPTH),
        .NSLICE   (NSLICE),
        .ROW_W    (ROW_W)
    ) u_decode (
        .bus_addr(bus_addr),
        .hit     (hit),
        .sel     (sel),
        .row     (brow)
    );

    assign u_we_ok = user_we && (MODE != WSM_HOST_WR);
    assign b_we_ok = bus_wr && hit && (MODE != WSM_USER_WR);
    assign b_rd_ok = bus_rd && hit && (MODE != WSM_HOST_WR);

    for (genvar gi = 0; gi < NSLICE; gi++) begin : g_slice
        localparam int CW = slice_width(DATA_W, gi);
        logic [CW-1:0] s_urd;
        logic [CW-1:0] s_brd;

        wsm_slice #(
            .WIDTH(CW),
            .DEPTH(DEPTH),
            .ROW_W(ROW_W)
        ) u_slice (
            .clk    (clk),
            .rst_n  (rst_n),
            .u_we   (u_we_ok),
            .u_addr (user_addr),
            .u_wdata(user_wdata[gi*16 +: CW]),
            .u_rdata(s_urd),
            .b_we   (b_we_ok && sel[gi]),
            .b_addr (brow),
            .b_wdata(bus_wdata[CW-1:0]),
            .b_rdata(s_brd)
        );

        assign user_word[gi*16 +: CW] = s_urd;
        assign bus_slice_rd[gi]       = 16'(s_brd);
    end

    always_comb begin
        st_d      = st_q;
        st_d.urd  = (MODE == WSM_USER_WR) ? '0 : user_word;
        st_d.bvld = b_rd_ok;
        st_d.brd  = '0;
        if (b_rd_ok) begin
            for (int i = 0; i < NSLICE; i++) begin
                if (sel[i]) begin
                    st_d.brd = bus_slice_rd[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign user_rdata = st_q.urd;
    assign bus_rdata  = st_q.brd;
    assign bus_rvalid = st_q.bvld;

endmodule

// File: rtl/wsm_core_chk.sv
module wsm_core_chk
    import wsm_pkg::*;
#(
    parameter int        DATA_W    = 23,
    parameter int        DEPTH     = 32,
    parameter int        BASE_ADDR = 256,
    parameter int        BUS_AW    = 16,
    parameter wsm_mode_e MODE      = WSM_BIDIR
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] user_rdata,
    input logic [BUS_AW-1:0] bus_addr,
    input logic              bus_rd,
    input logic [15:0]       bus_rdata,
    input logic              bus_rvalid
);
    localparam int NSLICE  = slice_count(DATA_W);
    localparam int SPAN    = NSLICE * DEPTH;
    localparam int LAST_W  = slice_width(DATA_W, NSLICE - 1);
    localparam int LAST_LO = BASE_ADDR + (NSLICE - 1) * DEPTH;

    logic outside;
    assign outside = (32'(bus_addr) < 32'(BASE_ADDR)) ||
                     (32'(bus_addr) >= 32'(BASE_ADDR + SPAN));

    // R4
    rvalid_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_rd));

    // R5
    outside_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && outside) |=> !bus_rvalid);

    if (LAST_W < 16) begin : g_narrow
        // R3
        narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(bus_rd) && (32'($past(bus_addr)) >= 32'(LAST_LO)) &&
             (32'($past(bus_addr)) < 32'(BASE_ADDR + SPAN)))
            |-> (bus_rdata[15:LAST_W] == '0));
    end

    if (MODE == WSM_USER_WR) begin : g_capture
        // R8
        capture_user_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            user_rdata == '0);
    end

    if (MODE == WSM_HOST_WR) begin : g_playback
        // R9
        playback_no_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !bus_rvalid);
    end

endmodule

bind wsm_core wsm_core_chk #(
    .DATA_W   (DATA_W),
    .DEPTH    (DEPTH),
    .BASE_ADDR(BASE_ADDR),
    .BUS_AW   (BUS_AW),
    .MODE     (MODE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .user_rdata(user_rdata),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .bus_rvalid(bus_rvalid)
);

// File: tb/wsm_core_test.sv
module wsm_core_test;
    import wsm_pkg::*;

    localparam int DATA_W = 23;
    localparam int DEPTH  = 32;
    localparam int BASE   = 256;
    localparam int BUS_AW = 16;
    localparam int ROW_W  = 5;
    localparam int NSL    = 2;
    localparam int SPAN   = NSL * DEPTH;
    localparam int LAST_W = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ROW_W-1:0]  user_addr = '0;
    logic [DATA_W-1:0] user_wdata = '0;
    logic              user_we = 1'b0;
    logic [BUS_AW-1:0] bus_addr = '0;
    logic [15:0]       bus_wdata = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;

    logic [DATA_W-1:0] urd_bi, urd_uw, urd_hw;
    logic [15:0]       brd_bi, brd_uw, brd_hw;
    logic              bv_bi, bv_uw, bv_hw;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [15:0] m_bi [SPAN];
    logic [15:0] m_uw [SPAN];
    logic [15:0] m_hw [SPAN];

    always #4 clk = ~clk;

    wsm_core #(.DATA_W(DATA_W), .DEPTH(DEPTH), .BASE_ADDR(BASE), .BUS_AW(BUS_AW),
               .MODE(WSM_BIDIR)) uut (
        .clk(clk), .rst_n(rst_n), .user_addr(user_addr), .user_wdata(user_wdata),
        .user_we(user_we), .user_rdata(urd_bi), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(brd_bi), .bus_rvalid(bv_bi));

    wsm_core #(.DATA_W(DATA_W), .DEPTH(DEPTH), .BASE_ADDR(BASE), .BUS_AW(BUS_AW),
               .MODE(WSM_USER_WR)) uut_uw (
        .clk(clk), .rst_n(rst_n), .user_addr(user_addr), .user_wdata(user_wdata),
        .user_we(user_we), .user_rdata(urd_uw), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(brd_uw), .bus_rvalid(bv_uw));

    wsm_core #(.DATA_W(DATA_W), .DEPTH(DEPTH), .BASE_ADDR(BASE), .BUS_AW(BUS_AW),
               .MODE(WSM_HOST_WR)) uut_hw (
        .clk(clk), .rst_n(rst_n), .user_addr(user_addr), .user_wdata(user_wdata),
        .user_we(user_we), .user_rdata(urd_hw), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(brd_hw), .bus_rvalid(bv_hw));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit in_win(input int a);
        return (a >= BASE) && (a < BASE + SPAN);
    endfunction

    function automatic logic [15:0] mask_for(input int idx);
        return (idx >= (NSL - 1) * DEPTH) ? 16'((1 << LAST_W) - 1) : 16'hFFFF;
    endfunction

    function automatic logic [31:0] word_of(input int sel, input int row);
        logic [31:0] w;
        w = '0;
        for (int i = 0; i < NSL; i++) begin
            if (sel == 0) w |= 32'(m_bi[row + i * DEPTH]) << (16 * i);
            else if (sel == 1) w |= 32'(m_uw[row + i * DEPTH]) << (16 * i);
            else w |= 32'(m_hw[row + i * DEPTH]) << (16 * i);
        end
        return w;
    endfunction

    task automatic model_user(input int row, input logic [DATA_W-1:0] d);
        for (int i = 0; i < NSL; i++) begin
            m_bi[row + i * DEPTH] = 16'(32'(d) >> (16 * i)) & mask_for(row + i * DEPTH);
            m_uw[row + i * DEPTH] = 16'(32'(d) >> (16 * i)) & mask_for(row + i * DEPTH);
        end
    endtask

    task automatic model_bus(input int a, input logic [15:0] d);
        if (in_win(a)) begin
            m_bi[a - BASE] = d & mask_for(a - BASE);
            m_hw[a - BASE] = d & mask_for(a - BASE);
        end
    endtask

    task automatic bus_write(input int a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = BUS_AW'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_bus(a, d);
        // R4: no read strobe, so no valid after a write
        chk("R4 rvalid idle", 32'(bv_bi), 32'd0);
    endtask

    task automatic user_write(input int row, input logic [DATA_W-1:0] d);
        @(negedge clk);
        user_addr = ROW_W'(row); user_wdata = d; user_we = 1'b1;
        @(negedge clk);
        user_we = 1'b0;
        model_user(row, d);
    endtask

    task automatic both_write(input int row, input logic [DATA_W-1:0] ud,
                              input int slc, input logic [15:0] bd);
        @(negedge clk);
        user_addr = ROW_W'(row); user_wdata = ud; user_we = 1'b1;
        bus_addr = BUS_AW'(BASE + row + slc * DEPTH); bus_wdata = bd; bus_wr = 1'b1;
        @(negedge clk);
        user_we = 1'b0; bus_wr = 1'b0;
        model_user(row, ud);
        model_bus(BASE + row + slc * DEPTH, bd);
    endtask

    task automatic bus_check(input string req, input int a);
        @(negedge clk);
        bus_addr = BUS_AW'(a); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        if (in_win(a)) begin
            chk({req, " bidir valid"}, 32'(bv_bi), 32'd1);
            chk({req, " bidir data"}, 32'(brd_bi), 32'(m_bi[a - BASE]));
            chk("R8 capture host read valid", 32'(bv_uw), 32'd1);
            chk("R8 capture host read data", 32'(brd_uw), 32'(m_uw[a - BASE]));
        end else begin
            chk("R5 outside no valid", 32'(bv_bi), 32'd0);
            chk("R5 outside no valid capture", 32'(bv_uw), 32'd0);
        end
        chk("R9 playback no rvalid", 32'(bv_hw), 32'd0);
    endtask

    task automatic user_check(input string req, input int row);
        @(negedge clk);
        user_addr = ROW_W'(row);
        @(negedge clk);
        @(negedge clk);
        chk({req, " bidir word"}, 32'(urd_bi), word_of(0, row));
        chk("R9 playback user word", 32'(urd_hw), word_of(2, row));
        chk("R8 capture user zero", 32'(urd_uw), 32'd0);
    endtask

    task automatic t_reset();
        for (int r = 0; r < DEPTH; r++) user_check("R1 reset user", r);
        for (int a = BASE; a < BASE + SPAN; a++) bus_check("R1 reset bus", a);
    endtask

    task automatic t_host_to_user();
        bus_write(BASE + 5, 16'hBEEF);
        bus_write(BASE + 5 + DEPTH, 16'hFFFF);
        user_check("R7 host to user", 5);
        bus_check("R3 narrow truncation", BASE + 5 + DEPTH);
        bus_write(BASE + DEPTH - 1, 16'h1234);
        bus_write(BASE + SPAN - 1, 16'h0055);
        user_check("R2 last row mapping", DEPTH - 1);
    endtask

    task automatic t_user_to_host();
        user_write(9, 23'h5A5A5A);
        bus_check("R2 slice0 of user word", BASE + 9);
        bus_check("R2 slice1 of user word", BASE + 9 + DEPTH);
        user_check("R6 user write read", 9);
        user_write(0, 23'h7FFFFF);
        bus_check("R3 narrow upper zero", BASE + DEPTH);
        user_check("R6 user row0", 0);
    endtask

    task automatic t_window();
        bus_check("R5 below window", BASE - 1);
        bus_check("R5 above window", BASE + SPAN);
        bus_write(BASE - 1, 16'hAAAA);
        bus_write(BASE + SPAN, 16'h5555);
        user_check("R5 outside write ignored row0", 0);
        user_check("R5 outside write ignored last", DEPTH - 1);
        bus_check("R4 last in window", BASE + SPAN - 1);
        bus_check("R4 first in window", BASE);
    endtask

    task automatic t_collision();
        both_write(3, 23'h2AAAAA, 0, 16'h1357);
        user_check("R10 collision slice0", 3);
        bus_check("R10 collision host slice", BASE + 3);
        bus_check("R10 collision user slice", BASE + 3 + DEPTH);
        both_write(4, 23'h123456, 1, 16'h00F0);
        user_check("R10 collision narrow slice", 4);
        bus_check("R10 collision narrow host", BASE + 4 + DEPTH);
    endtask

    task automatic t_mixed();
        for (int k = 0; k < 60; k++) begin
            int op  = int'($urandom_range(0, 3));
            int row = int'($urandom_range(0, DEPTH - 1));
            int a   = BASE + int'($urandom_range(0, SPAN - 1));
            case (op)
                0: user_write(row, DATA_W'($urandom));
                1: bus_write(a, 16'($urandom));
                2: user_check("R7 mixed user read", row);
                default: bus_check("R7 mixed host read", a);
            endcase
        end
    endtask

    initial begin
        for (int i = 0; i < SPAN; i++) begin
            m_bi[i] = '0; m_uw[i] = '0; m_hw[i] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_host_to_user();
        t_user_to_host();
        t_window();
        t_collision();
        t_mixed();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule